// File: doc/BRIEF.md
# Shared-Counter Six-Bit PWM Bank

This block generates a bank of pulse-width-modulated outputs that all run from a single free-running 6-bit counter. Because every channel uses the same counter, all channels have the same period of 64 counter steps. The counter steps only on cycles where the global run bit and the prescaler tick input are both high. So the period in clock cycles is 64 times the tick spacing.

Each channel holds a 7-bit duty value. The value is a 6-bit threshold plus one extension bit. A channel output is low while the zero-extended count is below the duty value, and high from that point to the end of the period. Setting the extension bit keeps the output low for the whole period. A duty value of zero keeps it high for the whole period.

Software never writes the active duty value directly. It writes a per-channel shadow register, and the active value takes the shadow contents only when the counter wraps from 63 to 0. A duty change therefore always starts on a period boundary and never produces a partial pulse.

Top module: `shpwm_bank`

## Requirements
- R1: While `rst_n` is low, every `pwm_out` bit is 0. Reset clears the counter, every shadow duty value and every active duty value to 0.
- R2: The counter advances by one, modulo 64, only on a clock edge where `run` and `tick_en` are both 1. Otherwise it holds its value, and so does every output.
- R3: For a live channel, `pwm_out` is 1 exactly when {0, count} >= active duty, compared as 7-bit unsigned numbers. The output is registered, so it reflects the count and the duty from the previous edge.
- R4: An active duty value with the extension bit (bit 6 of the 7-bit value) set keeps a live channel low for the whole period.
- R5: An active duty value of 0 keeps a live channel high for the whole period.
- R6: A pulse on `wr_stb[i]` stores `wr_duty[7*i+6:7*i]` in the shadow register of channel i. The output waveform does not change until the next wrap of the counter from 63 to 0, and at that wrap the active duty value is loaded from the shadow.
- R7: If a shadow write falls on the same edge as a wrap, the active duty value takes the previous shadow value. The newly written value takes effect only at the following wrap.
- R8: Channel i is live only when `ch_en[i]` is 1 and its mode field `ch_sel[2*i+1:2*i]` equals binary 10. A channel that is not live drives 0.
- R9: A channel that is not live at a wrap keeps its active duty value. When it becomes live again, it resumes with that old value.
- R10: All channels use the one counter, so two live channels with equal active duty values produce identical outputs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler tick; lets the counter step for one cycle |
| run | input | 1 | Global run bit; the counter steps only while it is high |
| ch_en | input | NCH | Per-channel enable |
| ch_sel | input | 2*NCH | Per-channel 2-bit mode field; 2'b10 selects PWM |
| wr_stb | input | NCH | Per-channel shadow write strobe |
| wr_duty | input | 7*NCH | Per-channel 7-bit shadow write data; bit 6 is the extension bit |
| pwm_out | output | NCH | Registered PWM outputs |

## Verification
Two events can land on the same clock edge: a shadow write and the counter wrap that copies the shadow into the active duty value. The bench tracks the counter phase in its own model. It raises a write strobe on exactly the cycle where the count sits at 63 with the tick high, so the write and the wrap share one edge. The check then counts the high cycles over the following period and expects the old duty value's count rather than the new one. A second full period must then show the new duty value.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;

  localparam int unsigned CNT_W  = 6;
  localparam int unsigned DUTY_W = CNT_W + 1;
  localparam logic [1:0]  SEL_PWM6 = 2'b10;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DUTY_W-1:0] duty_t;

  // Output level for one count/duty pair: the count is zero-extended first.
  function automatic logic level_high(cnt_t c, duty_t d);
    return {1'b0, c} >= d;
  endfunction

  // True on the last count before the wrap.
  function automatic logic at_top(cnt_t c);
    return &c;
  endfunction

  // A channel runs only when enabled and its mode field picks the PWM mode.
  function automatic logic chan_live(logic en, logic [1:0] sel);
    return en && (sel == SEL_PWM6);
  endfunction

endpackage

// File: rtl/shpwm_counter.sv
module shpwm_counter
  import shpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output cnt_t cnt,
  output logic wrap
);

  logic step;

  assign step = run & tick;
  assign wrap = step & at_top(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (step)  cnt <= cnt + cnt_t'(1);
  end

endmodule

// File: rtl/shpwm_channel.sv
module shpwm_channel
  import shpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  logic  wrap,
  input  cnt_t  cnt,
  input  logic  wr_stb,
  input  duty_t wr_data,
  output logic  pwm,
  output duty_t duty_act,
  output logic  reload
);

  duty_t shadow_q;

  // Only a live channel takes the shadow at a period boundary.
  assign reload = live & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= '0;
    else if (wr_stb) shadow_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      duty_act <= '0;
    else if (reload) duty_act <= shadow_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= live & level_high(cnt, duty_act);
  end

endmodule

// File: rtl/shpwm_bank.sv
module shpwm_bank
  import shpwm_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  run,
  input  logic [NCH-1:0]        ch_en,
  input  logic [2*NCH-1:0]      ch_sel,
  input  logic [NCH-1:0]        wr_stb,
  input  logic [DUTY_W*NCH-1:0] wr_duty,
  output logic [NCH-1:0]        pwm_out
);

  localparam int unsigned FLAT_W = DUTY_W * NCH;

  cnt_t              cnt;
  logic              wrap;
  logic [NCH-1:0]    live;
  logic [NCH-1:0]    reload;
  logic [FLAT_W-1:0] duty_act;

  shpwm_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick_en),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign live[g] = chan_live(ch_en[g], ch_sel[2*g +: 2]);

    shpwm_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (live[g]),
      .wrap     (wrap),
      .cnt      (cnt),
      .wr_stb   (wr_stb[g]),
      .wr_data  (wr_duty[g*DUTY_W +: DUTY_W]),
      .pwm      (pwm_out[g]),
      .duty_act (duty_act[g*DUTY_W +: DUTY_W]),
      .reload   (reload[g])
    );
  end

endmodule

// File: rtl/shpwm_bank_chk.sv
module shpwm_bank_chk
  import shpwm_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic                  tick_en,
  input cnt_t                  cnt,
  input logic                  wrap,
  input logic [NCH-1:0]        live,
  input logic [NCH-1:0]        reload,
  input logic [DUTY_W*NCH-1:0] duty_act,
  input logic [NCH-1:0]        pwm_out
);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en) |=> (cnt == cnt_t'($past(cnt) + 1'b1)));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick_en) |=> $stable(cnt));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !reload[g] |=> $stable(duty_act[g*DUTY_W +: DUTY_W]));

    p_ext_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (live[g] && duty_act[g*DUTY_W + DUTY_W - 1]) |=> !pwm_out[g]);

    p_zero_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live[g] && duty_act[g*DUTY_W +: DUTY_W] == '0) |=> pwm_out[g]);

    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !live[g] |=> !pwm_out[g]);

    p_no_stale_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !live[g]) |=> $stable(duty_act[g*DUTY_W +: DUTY_W]));
  end

endmodule

bind shpwm_bank shpwm_bank_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .tick_en  (tick_en),
  .cnt      (cnt),
  .wrap     (wrap),
  .live     (live),
  .reload   (reload),
  .duty_act (duty_act),
  .pwm_out  (pwm_out)
);

// File: tb/shpwm_bank_bench.sv
`timescale 1ns/1ps
module shpwm_bank_bench;

  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic             run = 1'b0;
  logic [NCH-1:0]   ch_en = '0;
  logic [2*NCH-1:0] ch_sel = '0;
  logic [NCH-1:0]   wr_stb = '0;
  logic [7*NCH-1:0] wr_duty = '0;
  logic [NCH-1:0]   pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_sh[NCH];
  int m_act[NCH];
  logic [NCH-1:0] m_out = '0;

  always #2 clk = ~clk;

  shpwm_bank #(.NCH(NCH)) u_shpwm_bank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .ch_en(ch_en), .ch_sel(ch_sel), .wr_stb(wr_stb), .wr_duty(wr_duty),
    .pwm_out(pwm_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_out = '0;
      for (int i = 0; i < NCH; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    end else begin
      bit wr_edge;
      wr_edge = run && tick_en && (m_cnt == 63);
      for (int i = 0; i < NCH; i++) begin
        bit on;
        on = ch_en[i] && (ch_sel[2*i +: 2] == 2'b10);
        m_out[i] = on && (m_cnt >= m_act[i]);
        if (on && wr_edge) m_act[i] = m_sh[i];
        if (wr_stb[i]) m_sh[i] = int'(wr_duty[7*i +: 7]);
      end
      if (run && tick_en) m_cnt = (m_cnt + 1) % 64;
    end
  end

  // per-cycle comparison against the model (R3 level rule, all channels)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pwm_out !== m_out) begin
        errors++;
        $display("FAIL R3 per-cycle model: pwm_out=%b expected %b at cnt %0d", pwm_out, m_out, m_cnt);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int v);
    @(negedge clk);
    wr_stb[ch] = 1'b1;
    wr_duty[7*ch +: 7] = 7'(v);
    @(negedge clk);
    wr_stb = '0;
  endtask

  task automatic count_hi(int ch, int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic wait_cnt(int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  initial begin
    int hi;
    int diff;
    cyc(3);
    chk("R1 outputs during reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 outputs after reset", int'(pwm_out), 0);

    ch_sel = {NCH{2'b10}};
    ch_en = '1;
    run = 1'b1;
    tick_en = 1'b1;
    wr(0, 20); wr(1, 0); wr(2, 64 + 5); wr(3, 63);
    cyc(140);
    count_hi(0, 64, hi); chk("R3 duty 20 high count", hi, 44);
    count_hi(1, 64, hi); chk("R5 duty 0 always high", hi, 64);
    count_hi(2, 64, hi); chk("R4 extension bit always low", hi, 0);
    count_hi(3, 64, hi); chk("R3 duty 63 high count", hi, 1);

    // R10: equal duty on two channels gives identical waveforms
    wr(3, 20);
    cyc(140);
    diff = 0;
    repeat (64) begin
      @(negedge clk);
      if (pwm_out[0] != pwm_out[3]) diff++;
    end
    chk("R10 shared counter mismatch cycles", diff, 0);

    // R6: mid-period write waits for the wrap
    wait_cnt(10);
    wr(0, 50);
    wait_cnt(30);
    @(negedge clk);
    chk("R6 old duty still active", int'(pwm_out[0]), 1);
    cyc(80);
    wait_cnt(30);
    @(negedge clk);
    chk("R6 new duty after wrap", int'(pwm_out[0]), 0);

    // R7: write on the wrap edge
    wait_cnt(63);
    wr_stb[0] = 1'b1;
    wr_duty[6:0] = 7'd10;
    hi = 0;
    for (int k = 1; k <= 65; k++) begin
      @(negedge clk);
      if (k == 1) wr_stb = '0;
      if (k >= 2) hi += int'(pwm_out[0]);
    end
    chk("R7 collision keeps old duty", hi, 14);
    count_hi(0, 64, hi);
    chk("R7 new duty next period", hi, 54);

    // R8/R9: disabled channel holds its active duty
    @(negedge clk);
    ch_en[1] = 1'b0;
    wr(1, 40);
    wait_cnt(63);
    cyc(3);
    chk("R8 disabled channel low", int'(pwm_out[1]), 0);
    wait_cnt(8);
    ch_en[1] = 1'b1;
    cyc(2);
    chk("R9 no reload while disabled", int'(pwm_out[1]), 1);

    // R8: mode field other than 10
    @(negedge clk);
    ch_sel[7:6] = 2'b01;
    cyc(2);
    count_hi(3, 64, hi); chk("R8 mode 01 low", hi, 0);
    ch_sel[7:6] = 2'b11;
    cyc(2);
    count_hi(3, 64, hi); chk("R8 mode 11 low", hi, 0);
    ch_sel[7:6] = 2'b10;

    // R2: run low freezes counter; sparse ticks stretch the period
    wait_cnt(5);
    run = 1'b0;
    cyc(2);
    count_hi(0, 30, hi); chk("R2 frozen counter output", hi, 0);
    run = 1'b1;
    for (int k = 0; k < 10 + 192; k++) begin
      @(negedge clk);
      if (k == 10) hi = 0;
      if (k >= 10) hi += int'(pwm_out[0]);
      tick_en = (k % 3 == 0);
    end
    chk("R2 tick every third cycle high count", hi, 162);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule